// File: doc/BRIEF.md
# Memory Card Host Address Decoder

This block sits between the parallel host bus of a flash memory card and the flash devices inside it. Each cycle it takes the host address, the two byte-lane card enables, the output and write enables, the register select, a density code and the write-protect switch. From these it produces one active-low chip enable per flash device pair, a selection of the even and odd device within the pair, the block number and the word offset inside the block, a select for the attribute space, and gated read and write strobes. The decoded request is registered once, so every output follows its inputs by one clock.

The boundary between the block field and the pair field depends on the density. Small cards use a 4-bit block number with the pair field above it. Large cards use a 5-bit block number, which moves the pair field up by one bit. By default the decoder ignores capacity, so an address past the end of the card aliases back onto a populated pair. With the fill option set, such an access reaches no device: a read returns a fixed fill word and a write is dropped. The read return path places flash or attribute data onto the host lanes that the card enables request.

Top module: `card_addr_dec`

## Requirements
- R1: While rst_ni is low, every pair enable and every strobe is high (inactive), dev_sel_o, blk_idx_o, blk_ofs_o and attr_sel_o are zero, and host_dq_oe_o is 00. Reset acts without waiting for a clock edge. Otherwise each output reflects the inputs sampled at the previous rising clk_i edge.
- R2: Density codes 0, 1, 2 and 3 are 2, 4, 8 and 10 MB cards with 1, 2, 4 and 5 populated pairs. For these codes the pair number is addr_i[25:21] and blk_idx_o is addr_i[20:17] zero-extended.
- R3: Density codes 4 and 5 are 16 and 20 MB cards with 4 and 5 pairs. Codes 6 and 7 decode like code 5. For codes 4 to 7 the pair number is addr_i[25:22] and blk_idx_o is addr_i[21:17].
- R4: blk_ofs_o equals addr_i[16:1] for every access.
- R5: dev_sel_o bit 0 enables the even device and bit 1 the odd device. Both card enables low gives 11. Only ce_lo_ni low gives 01 when addr_i[0]=0 and 10 when addr_i[0]=1. Only ce_hi_ni low gives 10.
- R6: With reg_ni low and a card enable low, attr_sel_o is 1, no pair enable is low, and flash_oe_no and flash_we_no stay high.
- R7: At most one pair enable is low at any time. With both card enables high, none is low.
- R8: With fill_en_i low, a pair number p that is not below the populated count n selects pair p mod n.
- R9: With fill_en_i high, an out-of-capacity common access enables no pair and drops the write strobe. A read returns 0000h when fill_ones_i is 0 and FFFFh when it is 1.
- R10: With wp_i high, flash_we_no stays high. attr_we_no goes low only when the address lies in the management window 4000h to 41FFh.
- R11: host_dq_oe_o bit 0 drives lanes 7..0 when ce_lo_ni and oe_ni are low, and bit 1 drives lanes 15..8 when ce_hi_ni and oe_ni are low. A word read returns the source unchanged. A low-lane-only read with addr_i[0]=1 places source bits 15..8 on lanes 7..0. Lanes that are not driven read as zero.
- R12: Common reads return flash_rdata_i and attribute reads return attr_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 26 | Host address |
| ce_lo_ni | input | 1 | Card enable for lanes 7..0, active low |
| ce_hi_ni | input | 1 | Card enable for lanes 15..8, active low |
| oe_ni | input | 1 | Host output enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| reg_ni | input | 1 | Attribute space select, active low |
| dens_i | input | 3 | Density code |
| wp_i | input | 1 | Write-protect switch, 1 = protected |
| fill_en_i | input | 1 | Replace out-of-capacity data with the fill word |
| fill_ones_i | input | 1 | Fill word select: 0 gives 0000h, 1 gives FFFFh |
| flash_rdata_i | input | 16 | Read data from the selected pair |
| attr_rdata_i | input | 16 | Read data from attribute space |
| pair_ce_no | output | 8 | Chip enable per device pair, active low |
| dev_sel_o | output | 2 | Odd/even device select within the pair |
| blk_idx_o | output | 5 | Block number |
| blk_ofs_o | output | 16 | Word offset within the block |
| attr_sel_o | output | 1 | Attribute space access |
| flash_oe_no | output | 1 | Flash read strobe, active low |
| flash_we_no | output | 1 | Gated flash write strobe, active low |
| attr_we_no | output | 1 | Gated attribute write strobe, active low |
| host_dq_o | output | 16 | Read data to the host |
| host_dq_oe_o | output | 2 | Lane drive enables (bit 1 = lanes 15..8) |

## Verification
Some properties are checked on every cycle: at most one pair is enabled, attribute accesses never touch flash, protection blocks flash writes, attribute writes under protection stay inside the management window, lanes are not driven without a read, the block offset tracks the address, and a fill read carries a uniform word. The exact field split for each density, the modulo alias for each card size, lane steering for byte reads and the choice of fill value can only be shown by the bench's address vectors, which carry expected values worked out by hand.

// File: rtl/cad_pkg.sv
package cad_pkg;

  typedef enum logic [2:0] {
    DENS_2M  = 3'd0,
    DENS_4M  = 3'd1,
    DENS_8M  = 3'd2,
    DENS_10M = 3'd3,
    DENS_16M = 3'd4,
    DENS_20M = 3'd5,
    DENS_R6  = 3'd6,
    DENS_R7  = 3'd7
  } dens_e;

  // populated pair count per density code
  function automatic logic [2:0] pairs_of(input logic [2:0] d);
    case (dens_e'(d))
      DENS_2M:  return 3'd1;
      DENS_4M:  return 3'd2;
      DENS_8M:  return 3'd4;
      DENS_16M: return 3'd4;
      default:  return 3'd5;
    endcase
  endfunction

  // large cards use a 5-bit block field
  function automatic logic wide_map(input logic [2:0] d);
    return d[2];
  endfunction

  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic swap;
    logic fill;
    logic fill_ones;
    logic attr;
  } rd_ctl_s;

endpackage

// File: rtl/cad_field_split.sv
module cad_field_split #(
  parameter int ADDR_W = 26,
  parameter int OFS_W  = 16,
  parameter int BLK_W  = 5,
  parameter int SEL_W  = ADDR_W - OFS_W - BLK_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [OFS_W-1:0]  ofs_o
);
  localparam int BLK_LSB    = OFS_W + 1;
  localparam int NARROW_LSB = BLK_LSB + BLK_W - 1;
  localparam int WIDE_LSB   = BLK_LSB + BLK_W;

  always_comb begin
    ofs_o = addr_i[BLK_LSB-1:1];
    if (wide_i) begin
      sel_o = {1'b0, addr_i[ADDR_W-1:WIDE_LSB]};
      blk_o = addr_i[WIDE_LSB-1:BLK_LSB];
    end else begin
      sel_o = addr_i[ADDR_W-1:NARROW_LSB];
      blk_o = {1'b0, addr_i[NARROW_LSB-1:BLK_LSB]};
    end
  end
endmodule

// File: rtl/cad_pair_sel.sv
module cad_pair_sel #(
  parameter int SEL_W     = 5,
  parameter int NUM_PAIRS = 8,
  parameter int CNT_W     = 3
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 en_i,
  input  logic                 fill_en_i,
  output logic [NUM_PAIRS-1:0] ce_no,
  output logic                 hit_o,
  output logic                 oor_o
);
  logic [SEL_W-1:0] cnt_w;
  logic [SEL_W-1:0] pick;

  always_comb begin
    cnt_w = SEL_W'(cnt_i);
    oor_o = (sel_i >= cnt_w);
    // no fill: upper addresses alias onto populated pairs
    pick  = oor_o ? (sel_i % cnt_w) : sel_i;
    hit_o = en_i && !(oor_o && fill_en_i) && (int'(pick) < NUM_PAIRS);
  end

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_ce
    assign ce_no[g] = !(hit_o && (pick == SEL_W'(g)));
  end
endmodule

// File: rtl/cad_lane_dec.sv
module cad_lane_dec (
  input  logic       ce_lo_ni,
  input  logic       ce_hi_ni,
  input  logic       a0_i,
  output logic       acc_o,
  output logic [1:0] dev_sel_o,
  output logic       swap_o
);
  always_comb begin
    acc_o        = !ce_lo_ni || !ce_hi_ni;
    dev_sel_o[0] = !ce_lo_ni && (!ce_hi_ni || !a0_i);
    dev_sel_o[1] = !ce_hi_ni || (!ce_lo_ni && a0_i);
    swap_o       = !ce_lo_ni && ce_hi_ni && a0_i;
  end
endmodule

// File: rtl/cad_rd_mux.sv
module cad_rd_mux
  import cad_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_ctl_s           ctl_i,
  input  logic [DATA_W-1:0] flash_rdata_i,
  input  logic [DATA_W-1:0] attr_rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [1:0]        dq_oe_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] src;
  logic [HALF-1:0]   lo;

  always_comb begin
    if (ctl_i.fill)      src = {DATA_W{ctl_i.fill_ones}};
    else if (ctl_i.attr) src = attr_rdata_i;
    else                 src = flash_rdata_i;
    lo      = ctl_i.swap ? src[DATA_W-1:HALF] : src[HALF-1:0];
    dq_o    = {ctl_i.rd_hi ? src[DATA_W-1:HALF] : {HALF{1'b0}},
               ctl_i.rd_lo ? lo : {HALF{1'b0}}};
    dq_oe_o = {ctl_i.rd_hi, ctl_i.rd_lo};
  end
endmodule

// File: rtl/card_addr_dec.sv
module card_addr_dec
  import cad_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int DATA_W     = 16,
  parameter int OFS_W      = 16,
  parameter int BLK_W      = 5,
  parameter int NUM_PAIRS  = 8,
  parameter int MGMT_BASE  = 'h4000,
  parameter int MGMT_LOG2  = 9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ce_lo_ni,
  input  logic                 ce_hi_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic                 reg_ni,
  input  logic [2:0]           dens_i,
  input  logic                 wp_i,
  input  logic                 fill_en_i,
  input  logic                 fill_ones_i,
  input  logic [DATA_W-1:0]    flash_rdata_i,
  input  logic [DATA_W-1:0]    attr_rdata_i,
  output logic [NUM_PAIRS-1:0] pair_ce_no,
  output logic [1:0]           dev_sel_o,
  output logic [BLK_W-1:0]     blk_idx_o,
  output logic [OFS_W-1:0]     blk_ofs_o,
  output logic                 attr_sel_o,
  output logic                 flash_oe_no,
  output logic                 flash_we_no,
  output logic                 attr_we_no,
  output logic [DATA_W-1:0]    host_dq_o,
  output logic [1:0]           host_dq_oe_o
);
  localparam int SEL_W  = ADDR_W - OFS_W - BLK_W;
  localparam int TAG_W  = ADDR_W - MGMT_LOG2;
  localparam logic [TAG_W-1:0] MGMT_TAG = TAG_W'(MGMT_BASE >> MGMT_LOG2);

  logic [SEL_W-1:0]     sel;
  logic [BLK_W-1:0]     blk_d;
  logic [OFS_W-1:0]     ofs_d;
  logic [NUM_PAIRS-1:0] ce_d;
  logic                 hit, oor, acc, swap;
  logic [1:0]           dev_d;
  logic                 common, attr, mgmt, fill_hit;
  logic                 foe_d, fwe_d, awe_d;
  rd_ctl_s              rd_d, rd_q;

  cad_field_split #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .BLK_W(BLK_W), .SEL_W(SEL_W)
  ) u_split (
    .addr_i(addr_i), .wide_i(wide_map(dens_i)),
    .sel_o(sel), .blk_o(blk_d), .ofs_o(ofs_d)
  );

  cad_lane_dec u_lane (
    .ce_lo_ni(ce_lo_ni), .ce_hi_ni(ce_hi_ni), .a0_i(addr_i[0]),
    .acc_o(acc), .dev_sel_o(dev_d), .swap_o(swap)
  );

  always_comb begin
    common = acc && reg_ni;
    attr   = acc && !reg_ni;
  end

  cad_pair_sel #(
    .SEL_W(SEL_W), .NUM_PAIRS(NUM_PAIRS), .CNT_W(3)
  ) u_pair (
    .sel_i(sel), .cnt_i(pairs_of(dens_i)), .en_i(common),
    .fill_en_i(fill_en_i), .ce_no(ce_d), .hit_o(hit), .oor_o(oor)
  );

  always_comb begin
    fill_hit = common && oor && fill_en_i;
    mgmt     = (addr_i[ADDR_W-1:MGMT_LOG2] == MGMT_TAG);
    foe_d    = !(hit && !oe_ni);
    fwe_d    = !(hit && !we_ni && !wp_i);
    awe_d    = !(attr && !we_ni && (!wp_i || mgmt));
    rd_d.rd_lo     = !ce_lo_ni && !oe_ni;
    rd_d.rd_hi     = !ce_hi_ni && !oe_ni;
    rd_d.swap      = swap;
    rd_d.fill      = fill_hit;
    rd_d.fill_ones = fill_ones_i;
    rd_d.attr      = attr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_ce_no  <= '1;
      dev_sel_o   <= '0;
      blk_idx_o   <= '0;
      blk_ofs_o   <= '0;
      attr_sel_o  <= 1'b0;
      flash_oe_no <= 1'b1;
      flash_we_no <= 1'b1;
      attr_we_no  <= 1'b1;
      rd_q        <= '0;
    end else begin
      pair_ce_no  <= ce_d;
      dev_sel_o   <= dev_d;
      blk_idx_o   <= blk_d;
      blk_ofs_o   <= ofs_d;
      attr_sel_o  <= attr;
      flash_oe_no <= foe_d;
      flash_we_no <= fwe_d;
      attr_we_no  <= awe_d;
      rd_q        <= rd_d;
    end
  end

  cad_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .ctl_i(rd_q), .flash_rdata_i(flash_rdata_i), .attr_rdata_i(attr_rdata_i),
    .dq_o(host_dq_o), .dq_oe_o(host_dq_oe_o)
  );
endmodule

// File: rtl/cad_chk.sv
module cad_chk #(
  parameter int ADDR_W    = 26,
  parameter int DATA_W    = 16,
  parameter int OFS_W     = 16,
  parameter int NUM_PAIRS = 8,
  parameter int MGMT_BASE = 'h4000,
  parameter int MGMT_LOG2 = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 ce_lo_ni,
  input logic                 ce_hi_ni,
  input logic                 oe_ni,
  input logic                 wp_i,
  input logic [NUM_PAIRS-1:0] pair_ce_no,
  input logic [OFS_W-1:0]     blk_ofs_o,
  input logic                 attr_sel_o,
  input logic                 flash_oe_no,
  input logic                 flash_we_no,
  input logic                 attr_we_no,
  input logic [DATA_W-1:0]    host_dq_o,
  input logic [1:0]           host_dq_oe_o
);
  localparam int TAG_W = ADDR_W - MGMT_LOG2;
  localparam logic [TAG_W-1:0] MGMT_TAG = TAG_W'(MGMT_BASE >> MGMT_LOG2);

  // set once a full cycle has passed out of reset, so $past is meaningful
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R7
  one_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~pair_ce_no));

  // R7
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ce_lo_ni && ce_hi_ni)) |-> (&pair_ce_no));

  // R6
  attr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attr_sel_o |-> ((&pair_ce_no) && flash_oe_no && flash_we_no));

  // R10
  wp_flash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !flash_we_no) |-> !$past(wp_i));

  // R10
  wp_attr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !attr_we_no && $past(wp_i))
      |-> ($past(addr_i[ADDR_W-1:MGMT_LOG2]) == MGMT_TAG));

  // R11
  no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(oe_ni)) |-> (host_dq_oe_o == 2'b00));

  // R4
  ofs_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (blk_ofs_o == $past(addr_i[OFS_W:1])));

  // R9
  fill_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_dq_oe_o == 2'b11 && flash_oe_no && !attr_sel_o)
      |-> (host_dq_o == '0 || host_dq_o == '1));
endmodule

bind card_addr_dec cad_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_PAIRS(NUM_PAIRS),
  .MGMT_BASE(MGMT_BASE), .MGMT_LOG2(MGMT_LOG2)
) u_chk (.*);

// File: tb/card_addr_dec_test.sv
module card_addr_dec_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [25:0] addr_i = '0;
  logic        ce_lo_ni = 1'b1, ce_hi_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic        reg_ni = 1'b1, wp_i = 1'b0, fill_en_i = 1'b0, fill_ones_i = 1'b0;
  logic [2:0]  dens_i = '0;
  logic [15:0] flash_rdata_i = 16'hA55A;
  logic [15:0] attr_rdata_i  = 16'h3C96;
  logic [7:0]  pair_ce_no;
  logic [1:0]  dev_sel_o, host_dq_oe_o;
  logic [4:0]  blk_idx_o;
  logic [15:0] blk_ofs_o, host_dq_o;
  logic        attr_sel_o, flash_oe_no, flash_we_no, attr_we_no;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  card_addr_dec uut (.*);

  typedef struct packed {
    logic [25:0] addr;
    logic lo_n, hi_n, oe_n, we_n, reg_n;
    logic [2:0] dens;
    logic wp, fen, fone;
    logic [7:0] ce;
    logic [1:0] lanes;
    logic [4:0] blk;
    logic [15:0] ofs;
    logic attr, foe_n, fwe_n, awe_n;
    logic [15:0] dq;
    logic [1:0] dqoe;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{26'h0000002,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0, 8'hFE,2'b11,5'd0, 16'h0001,1'b0,1'b0,1'b1,1'b1,16'hA55A,2'b11},
    '{26'h0921235,1'b0,1'b1,1'b0,1'b1,1'b1,3'd3,1'b0,1'b0,1'b0, 8'hEF,2'b10,5'd9, 16'h091A,1'b0,1'b0,1'b1,1'b1,16'h00A5,2'b01},
    '{26'h0EA0004,1'b1,1'b0,1'b1,1'b0,1'b1,3'd4,1'b0,1'b0,1'b0, 8'hF7,2'b10,5'd21,16'h0002,1'b0,1'b1,1'b0,1'b1,16'h0000,2'b00},
    '{26'h13E0000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd5,1'b1,1'b0,1'b0, 8'hEF,2'b11,5'd31,16'h0000,1'b0,1'b1,1'b1,1'b1,16'h0000,2'b00},
    '{26'h0C40000,1'b0,1'b0,1'b0,1'b1,1'b1,3'd2,1'b0,1'b0,1'b0, 8'hFB,2'b11,5'd2, 16'h0000,1'b0,1'b0,1'b1,1'b1,16'hA55A,2'b11},
    '{26'h0C40000,1'b0,1'b0,1'b0,1'b1,1'b1,3'd2,1'b0,1'b1,1'b0, 8'hFF,2'b11,5'd2, 16'h0000,1'b0,1'b1,1'b1,1'b1,16'h0000,2'b11},
    '{26'h0004000,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0, 8'hFF,2'b01,5'd0, 16'h2000,1'b1,1'b1,1'b1,1'b0,16'h0000,2'b00},
    '{26'h0000010,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,1'b1,1'b0,1'b0, 8'hFF,2'b01,5'd0, 16'h0008,1'b1,1'b1,1'b1,1'b1,16'h0000,2'b00},
    '{26'h0000010,1'b0,1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hFF,2'b01,5'd0, 16'h0008,1'b1,1'b1,1'b1,1'b0,16'h0000,2'b00},
    '{26'h0000000,1'b1,1'b1,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0, 8'hFF,2'b00,5'd0, 16'h0000,1'b0,1'b1,1'b1,1'b1,16'h0000,2'b00},
    '{26'h03FFFFE,1'b0,1'b0,1'b0,1'b1,1'b1,3'd1,1'b0,1'b0,1'b0, 8'hFD,2'b11,5'd15,16'hFFFF,1'b0,1'b0,1'b1,1'b1,16'hA55A,2'b11},
    '{26'h0600000,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0, 8'hFE,2'b11,5'd0, 16'h0000,1'b0,1'b0,1'b1,1'b1,16'hA55A,2'b11},
    '{26'h0200000,1'b0,1'b1,1'b0,1'b1,1'b1,3'd4,1'b0,1'b0,1'b0, 8'hFE,2'b01,5'd16,16'h0000,1'b0,1'b0,1'b1,1'b1,16'h005A,2'b01},
    '{26'h0A00000,1'b0,1'b0,1'b1,1'b0,1'b1,3'd3,1'b0,1'b1,1'b0, 8'hFF,2'b11,5'd0, 16'h0000,1'b0,1'b1,1'b1,1'b1,16'h0000,2'b00},
    '{26'h0200000,1'b0,1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,1'b1,1'b1, 8'hFF,2'b11,5'd0, 16'h0000,1'b0,1'b1,1'b1,1'b1,16'hFFFF,2'b11},
    '{26'h0000002,1'b0,1'b0,1'b0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b0, 8'hFF,2'b11,5'd0, 16'h0001,1'b1,1'b1,1'b1,1'b1,16'h3C96,2'b11},
    '{26'h0000000,1'b1,1'b0,1'b0,1'b1,1'b1,3'd0,1'b0,1'b0,1'b0, 8'hFE,2'b10,5'd0, 16'h0000,1'b0,1'b0,1'b1,1'b1,16'hA500,2'b10}
  };

  localparam string VTAG [NV] = '{
    "R2 R4 R5 R11 word read", "R2 R5 R11 odd byte on low lane", "R3 R5 R10 high-lane write",
    "R3 R10 protected flash write", "R8 alias 8MB", "R9 fill zero", "R6 R10 mgmt write protected",
    "R10 attr write blocked", "R6 attr write open", "R7 R11 no enable", "R2 R4 top of pair",
    "R8 alias 2MB", "R3 R11 wide block field", "R9 fill drops write", "R9 fill ones",
    "R6 R12 attr read", "R5 R11 high lane read"
  };

  function automatic logic [52:0] outs();
    return {pair_ce_no, dev_sel_o, blk_idx_o, blk_ofs_o, attr_sel_o,
            flash_oe_no, flash_we_no, attr_we_no, host_dq_o, host_dq_oe_o};
  endfunction

  task automatic check(input string tag, input logic [52:0] act, input logic [52:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr_i = v.addr; ce_lo_ni = v.lo_n; ce_hi_ni = v.hi_n; oe_ni = v.oe_n;
    we_ni = v.we_n; reg_ni = v.reg_n; dens_i = v.dens; wp_i = v.wp;
    fill_en_i = v.fen; fill_ones_i = v.fone;
  endtask

  function automatic logic [52:0] expect_of(input vec_t v);
    return {v.ce, v.lanes, v.blk, v.ofs, v.attr, v.foe_n, v.fwe_n, v.awe_n, v.dq, v.dqoe};
  endfunction

  localparam logic [52:0] IDLE = {8'hFF, 2'b00, 5'd0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 2'b00};

  initial begin
    // R1: active inputs during reset must not reach the outputs
    drive(VECS[0]);
    repeat (3) @(negedge clk_i);
    check("R1 idle in reset", outs(), IDLE);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      @(negedge clk_i);
      check(VTAG[i], outs(), expect_of(VECS[i]));
    end

    // R1: one-cycle latency, old value holds until the edge
    @(negedge clk_i);
    drive(VECS[10]);
    #1 check("R1 holds before edge", outs(), expect_of(VECS[NV-1]));
    @(negedge clk_i);
    check("R1 updates after edge", outs(), expect_of(VECS[10]));

    // R1: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 check("R1 async reset", outs(), IDLE);
    @(negedge clk_i);
    check("R1 held in reset", outs(), IDLE);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 resumes after reset", outs(), expect_of(VECS[10]));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule